// File: doc/BRIEF.md
# Cluster Power Gating Sequencer

This block sits in an always-on SoC domain. It drives the power controls of two CPU clusters. Software writes a command register to ask for one cluster to be powered down or powered up. The block then steps that cluster's five control outputs through a fixed order, with a programmable settling wait between steps. The five outputs are: the bridge enable, the reset, the isolation enable, the clock enable and the power-switch enable.

The three domains may only take the states "everything on", "everything off", or "one cluster off with the other cluster and the SoC on". The SoC domain never powers itself off through this block. So the block refuses any power-down that would leave no cluster powered, and it raises a sticky error flag. A request to a cluster that is still sequencing is dropped, and a sticky busy flag is raised.

A status register gives each cluster's state, the two flags and each cluster's idle/standby indication. Software can read it before it asks for a power-down. A one-cycle done pulse per cluster marks the end of each sequence.

Top module: `cl_pwr_seq`

## Requirements
- R1: After reset:
  - both clusters are in state ON (code 1);
  - bridge enable, reset release (`cl_rst_n`), clock enable and power enable are all 1;
  - isolation is 0;
  - the delay register reads 4;
  - both flags are 0.
- R2: Register map:
  - A write to address 0 is a command. Bit 0 powers down cluster 0, bit 1 powers up cluster 0, bit 2 powers down cluster 1, bit 3 powers up cluster 1, and bit 7 clears both flags.
  - Address 1 is the read/write settling delay D.
  - Address 2 reads status: bit 7 busy, bit 6 error, bits 5:4 idle inputs, bits 3:2 cluster 1 state, bits 1:0 cluster 0 state.
  - Reads of addresses 0 and 3 return 0.
- R3: An accepted power-down moves state to GOING_DOWN (code 2). It then takes five steps, D+1 cycles apart, the first on the accepting clock edge. The steps are, in order: bridge off, reset asserted, isolation on, clock off, power off.
- R4: An accepted power-up moves state to GOING_UP (code 3). It takes the same spacing and the reverse order: power on, clock on, isolation off, reset released, bridge on.
- R5: D+1 cycles after the last step, the state becomes OFF (code 0) or ON (code 1), and that cluster's done output is high for exactly one cycle.
- R6: While a cluster is OFF:
  - its clock enable is 0;
  - its reset is asserted;
  - its isolation is 1;
  - its power enable is 0.
- R7: A power-down request is rejected, and the error flag is set, when the other cluster is not ON. This includes the case where both clusters are asked to power down in the same write. A rejected request changes no output.
- R8: A request to a cluster in GOING_DOWN or GOING_UP is ignored and sets the busy flag. The running sequence keeps its timing.
- R9: A power-down to an OFF cluster, a power-up to an ON cluster, and a write that sets both bits of one cluster all have no effect and set no flag.
- R10: A new value written to D sets the step spacing of sequences started afterwards. D=0 gives one step per cycle.
- R11: The status idle field follows the `cl_idle` inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on `reg_addr`) |
| cl_idle | input | 2 | Per-cluster idle/standby indication |
| bridge_en | output | 2 | Per-cluster async bridge enable |
| cl_rst_n | output | 2 | Per-cluster reset, active low |
| iso_en | output | 2 | Per-cluster isolation enable |
| clk_en | output | 2 | Per-cluster clock enable |
| pwr_en | output | 2 | Per-cluster power switch enable |
| seq_done | output | 2 | Per-cluster one-cycle sequence-complete pulse |
| cl_state | output | 4 | Cluster states: bits 1:0 cluster 0, bits 3:2 cluster 1 |
| err_flag | output | 1 | Sticky illegal-request flag |
| busy_flag | output | 1 | Sticky request-while-sequencing flag |

## Verification
The ordering and legality properties assume three things about the inputs:
- `rst_n` is low at start;
- the register inputs are free of unknowns and change only between rising edges;
- the delay value stays within the register width.

The stimulus respects this by changing every input on falling edges and by parking the write strobe low between commands. Power-downs are issued only from legal states, except where a request is deliberately illegal to test rejection. The single-power-enable property therefore holds across the whole run.

// File: rtl/cl_pwr_seq.sv
module cl_pwr_seq #(
  parameter int DLY_W   = 8,
  parameter int DLY_RST = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [1:0] cl_idle,
  output logic [1:0] bridge_en,
  output logic [1:0] cl_rst_n,
  output logic [1:0] iso_en,
  output logic [1:0] clk_en,
  output logic [1:0] pwr_en,
  output logic [1:0] seq_done,
  output logic [3:0] cl_state,
  output logic       err_flag,
  output logic       busy_flag
);
  localparam logic [1:0] S_OFF = 2'd0, S_ON = 2'd1, S_DN = 2'd2, S_UP = 2'd3;
  localparam logic [2:0] LVL_MAX = 3'd5;

  logic [DLY_W-1:0] dly;
  logic [1:0] dn_req, up_req, err_hit, busy_hit;
  logic cmd, clr;

  assign cmd = reg_we && (reg_addr == 2'd0);
  assign clr = cmd && reg_wdata[7];

  for (genvar i = 0; i < 2; i++) begin : g_cl
    localparam int O = 1 - i;
    logic [1:0] st;
    logic [2:0] lvl;
    logic [DLY_W-1:0] cnt;
    logic done_q, dn_ok, up_ok;

    assign dn_req[i]   = cmd & reg_wdata[2*i] & ~reg_wdata[2*i+1];
    assign up_req[i]   = cmd & reg_wdata[2*i+1] & ~reg_wdata[2*i];
    assign dn_ok       = dn_req[i] && st == S_ON && cl_state[2*O +: 2] == S_ON && !dn_req[O];
    assign up_ok       = up_req[i] && st == S_OFF;
    assign err_hit[i]  = dn_req[i] && st == S_ON && !dn_ok;
    assign busy_hit[i] = (dn_req[i] | up_req[i]) & st[1];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st     <= S_ON;
        lvl    <= 3'd0;
        cnt    <= '0;
        done_q <= 1'b0;
      end else begin
        done_q <= 1'b0;
        case (st)
          S_ON:  if (dn_ok) begin st <= S_DN; lvl <= 3'd1; cnt <= dly; end
          S_OFF: if (up_ok) begin st <= S_UP; lvl <= 3'd4; cnt <= dly; end
          S_DN:
            if (cnt != '0) cnt <= cnt - 1'b1;
            else if (lvl == LVL_MAX) begin st <= S_OFF; done_q <= 1'b1; end
            else begin lvl <= lvl + 3'd1; cnt <= dly; end
          default:
            if (cnt != '0) cnt <= cnt - 1'b1;
            else if (lvl == 3'd0) begin st <= S_ON; done_q <= 1'b1; end
            else begin lvl <= lvl - 3'd1; cnt <= dly; end
        endcase
      end
    end

    assign cl_state[2*i +: 2] = st;
    assign seq_done[i]  = done_q;
    assign bridge_en[i] = lvl < 3'd1;
    assign cl_rst_n[i]  = lvl < 3'd2;
    assign iso_en[i]    = lvl >= 3'd3;
    assign clk_en[i]    = lvl < 3'd4;
    assign pwr_en[i]    = lvl < 3'd5;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly       <= DLY_W'(DLY_RST);
      err_flag  <= 1'b0;
      busy_flag <= 1'b0;
    end else begin
      if (reg_we && reg_addr == 2'd1) dly <= reg_wdata[DLY_W-1:0];
      err_flag  <= (err_flag & ~clr) | (|err_hit);
      busy_flag <= (busy_flag & ~clr) | (|busy_hit);
    end
  end

  always_comb begin
    case (reg_addr)
      2'd1:    reg_rdata = 8'(dly);
      2'd2:    reg_rdata = {busy_flag, err_flag, cl_idle, cl_state};
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/cl_pwr_seq_chk.sv
module cl_pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] bridge_en,
  input logic [1:0] cl_rst_n,
  input logic [1:0] iso_en,
  input logic [1:0] clk_en,
  input logic [1:0] pwr_en,
  input logic [1:0] seq_done,
  input logic [3:0] cl_state
);
  for (genvar i = 0; i < 2; i++) begin : g_chk
    assert_iso_after_rst_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(iso_en[i]) |-> !cl_rst_n[i] && !bridge_en[i]);
    assert_pwr_off_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_en[i]) |-> iso_en[i] && !clk_en[i] && !cl_rst_n[i] && !bridge_en[i]);
    assert_clk_after_pwr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_en[i]) |-> pwr_en[i] && iso_en[i]);
    assert_rst_rel_after_iso_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cl_rst_n[i]) |-> !iso_en[i] && clk_en[i]);
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done[i] |=> !seq_done[i]);
    assert_done_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done[i] |-> !cl_state[2*i+1] && $past(cl_state[2*i+1]));
    assert_off_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cl_state[2*i +: 2] == 2'd0 |-> !clk_en[i] && !cl_rst_n[i] && iso_en[i] && !pwr_en[i]);
  end

  assert_one_powered_R7: assert property (@(posedge clk) disable iff (!rst_n)
    |pwr_en);
endmodule

bind cl_pwr_seq cl_pwr_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bridge_en(bridge_en), .cl_rst_n(cl_rst_n),
  .iso_en(iso_en), .clk_en(clk_en), .pwr_en(pwr_en), .seq_done(seq_done),
  .cl_state(cl_state)
);

// File: tb/cl_pwr_seq_tb_top.sv
module cl_pwr_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd2;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [1:0] cl_idle = 2'b00;
  logic [1:0] bridge_en, cl_rst_n, iso_en, clk_en, pwr_en, seq_done;
  logic [3:0] cl_state;
  logic err_flag, busy_flag;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  cl_pwr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cl_idle(cl_idle),
    .bridge_en(bridge_en), .cl_rst_n(cl_rst_n), .iso_en(iso_en),
    .clk_en(clk_en), .pwr_en(pwr_en), .seq_done(seq_done),
    .cl_state(cl_state), .err_flag(err_flag), .busy_flag(busy_flag)
  );

  // {addr[27:26], wdata[25:18], idle[17:16], wait[15:8], expected status[7:0]}
  localparam logic [27:0] VEC [10] = '{
    {2'd3, 8'h00, 2'd0, 8'd0,  8'h05},  // R1 status after reset
    {2'd0, 8'h01, 2'd0, 8'd30, 8'h04},  // R3 power down cluster 0
    {2'd0, 8'h04, 2'd0, 8'd2,  8'h44},  // R7 cluster 1 down rejected
    {2'd0, 8'h80, 2'd0, 8'd1,  8'h04},  // R2 flag clear
    {2'd0, 8'h01, 2'd0, 8'd2,  8'h04},  // R9 down to OFF cluster
    {2'd0, 8'h02, 2'd0, 8'd30, 8'h05},  // R4 power up cluster 0
    {2'd0, 8'h02, 2'd0, 8'd2,  8'h05},  // R9 up to ON cluster
    {2'd0, 8'h03, 2'd0, 8'd2,  8'h05},  // R9 both bits of one cluster
    {2'd0, 8'h05, 2'd0, 8'd2,  8'h45},  // R7 both clusters down at once
    {2'd0, 8'h80, 2'd3, 8'd1,  8'h35}   // R11 idle field, R2 clear
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 2'd2;
  endtask

  function automatic logic [4:0] lvl_out(input int l);
    return {l < 1, l < 2, l >= 3, l < 4, l < 5};
  endfunction

  function automatic logic [4:0] c0_out();
    return {bridge_en[0], cl_rst_n[0], iso_en[0], clk_en[0], pwr_en[0]};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual expired expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset c0", 32'(c0_out()), 32'(lvl_out(0)));
    chk("R1 state in reset", 32'(cl_state), 32'h5);
    rst_n = 1'b1;
    @(negedge clk);
    reg_addr = 2'd1; #1;
    chk("R1 delay reset value", 32'(reg_rdata), 32'd4);
    chk("R1 flags", 32'({err_flag, busy_flag}), 32'd0);
    chk("R1 cluster 1 outputs", 32'({bridge_en[1], cl_rst_n[1], iso_en[1], clk_en[1], pwr_en[1]}), 32'(lvl_out(0)));
    reg_addr = 2'd0; #1;
    chk("R2 address 0 reads zero", 32'(reg_rdata), 32'd0);
    reg_addr = 2'd2;

    for (int v = 0; v < 10; v++) begin
      cl_idle = VEC[v][17:16];
      wr(VEC[v][27:26], VEC[v][25:18]);
      for (int w = 0; w < int'(VEC[v][15:8]); w++) @(negedge clk);
      #1;
      chk($sformatf("table vector %0d (R1/R2/R3/R4/R7/R9/R11)", v), 32'(reg_rdata), 32'(VEC[v][7:0]));
    end

    // R3 R5 R6: cycle-accurate power-down, D=4
    wr(2'd0, 8'h01);
    for (int k = 0; k <= 25; k++) begin
      if (k < 25) begin
        chk($sformatf("R3 down step k=%0d", k), 32'(c0_out()), 32'(lvl_out(1 + k / 5)));
        chk("R3 GOING_DOWN state", 32'(cl_state[1:0]), 32'd2);
      end else begin
        chk("R5 down final state", 32'(cl_state[1:0]), 32'd0);
        chk("R5 down done pulse", 32'(seq_done[0]), 32'd1);
        chk("R6 off gating", 32'({clk_en[0], cl_rst_n[0], iso_en[0], pwr_en[0]}), 32'b0010);
      end
      @(negedge clk);
    end
    chk("R5 done one cycle", 32'(seq_done[0]), 32'd0);
    chk("R6 cluster 1 untouched", 32'(pwr_en[1] & clk_en[1]), 32'd1);

    // R10 R4: D=0 power-up
    wr(2'd1, 8'h00);
    reg_addr = 2'd1; #1;
    chk("R10 delay readback", 32'(reg_rdata), 32'd0);
    wr(2'd0, 8'h02);
    for (int k = 0; k <= 5; k++) begin
      if (k < 5) begin
        chk($sformatf("R4 up step k=%0d", k), 32'(c0_out()), 32'(lvl_out(4 - k)));
        chk("R4 GOING_UP state", 32'(cl_state[1:0]), 32'd3);
      end else begin
        chk("R5 up final state", 32'(cl_state[1:0]), 32'd1);
        chk("R10 up done at D=0", 32'(seq_done[0]), 32'd1);
      end
      @(negedge clk);
    end
    wr(2'd1, 8'h04);

    // R8 R7: requests during a running sequence
    wr(2'd0, 8'h01);
    repeat (3) @(negedge clk);
    wr(2'd0, 8'h01);
    #1 chk("R8 busy status", 32'(reg_rdata), 32'hB6);
    wr(2'd0, 8'h04);
    #1 chk("R7 reject while other going down", 32'(reg_rdata), 32'hF6);
    chk("R7 cluster 1 kept on", 32'({bridge_en[1], cl_rst_n[1], clk_en[1], pwr_en[1]}), 32'hF);
    repeat (19) @(negedge clk);
    chk("R8 timing kept: not yet done", 32'(seq_done[0]), 32'd0);
    @(negedge clk);
    chk("R8 timing kept: done", 32'(seq_done[0]), 32'd1);
    chk("R8 final OFF", 32'(cl_state[1:0]), 32'd0);
    wr(2'd0, 8'h80);
    #1 chk("R2 clear flags", 32'(reg_rdata), 32'h34);
    wr(2'd0, 8'h02);
    repeat (30) @(negedge clk);
    #1 chk("R4 restored ON", 32'(reg_rdata), 32'h35);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule